// File: doc/BRIEF.md
# Compare-Match Event Timer

This peripheral is an up-counting timer on a small register bus with byte addresses. Each cycle, one of three tick-enable inputs is chosen as the clock source. That source passes through a divide-by-(N+1) prescaler and then advances the counter. Software reads the running count, writes a compare value, and is told of a match through a sticky status flag. The same flag, gated by an enable bit, drives the interrupt line.

In free-running mode the counter keeps going through a match and wraps at its full width. Software can therefore arm one-shot events as "now plus delta". In restart mode the counter returns to zero on the tick after a match, which gives a periodic event. The oscillator source has its own divider field that takes over when the oscillator path bit is set. A wait-mode bit is stored and read back, and has no effect inside the block.

Top module: `cmt_timer`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: Register offsets are control 0x00, prescaler 0x04, status 0x08, interrupt enable 0x0C, compare 0x10 and count 0x24. In control, only bit 0 (enable), bit 3 (wait flag), bits 8:6 (source), bit 9 (free-run) and bit 10 (oscillator path) are kept; other bits read 0. The prescaler keeps bits 15:0. Interrupt enable keeps bit 0. Compare keeps the counter width.
- R3: The count register at 0x24 is read-only, and writes to it leave the count unchanged.
- R4: While control bit 0 is 0, the count is held at 0 and the prescaler state is cleared. Writing 0 to the control register therefore resets the count.
- R5: Source code 1 counts `tick_bus`, code 2 counts `tick_per` and code 5 counts `tick_osc`. Unselected inputs and all other codes produce no counts.
- R6: The count advances once every N+1 selected ticks, where N is prescaler bits 11:0.
- R7: With source 5 and control bit 10 set, the divide ratio is prescaler bits 15:12 plus one instead.
- R8: A count step that lands on the compare value sets status bit 0 on the same clock edge.
- R9: With control bit 9 set, the count continues past a match and wraps from all ones to 0.
- R10: With control bit 9 clear, the first counted tick after a match loads the count with 0.
- R11: Writing 1 to status bit 0 clears it. Writing 0 leaves it set.
- R12: When a clearing write and a new match fall in the same cycle, the flag ends up set.
- R13: `irq` equals status bit 0 AND interrupt-enable bit 0. Clearing the enable masks `irq` but leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is 0 when low |
| bus_rdata | output | 32 | Combinational read data |
| tick_bus | input | 1 | Bus-clock tick enable (source 1) |
| tick_per | input | 1 | Peripheral-clock tick enable (source 2) |
| tick_osc | input | 1 | Oscillator tick enable (source 5) |
| irq | output | 1 | Compare interrupt |

## Verification
The properties assume that the tick inputs and bus strobes are synchronous to `clk` and that a write lasts one cycle. The flag-rise property also assumes the compare register does not change in the same cycle as the counted tick that hits it. The bench drives every input at the falling edge for a whole cycle and never writes the compare register while ticks are running. It builds the one deliberate clash, a status clear together with a matching tick, in a single controlled cycle. The bench uses an 8-bit counter so that the wrap at full width can be reached.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_PRE  = 8'h04;
    localparam logic [7:0] OFS_STAT = 8'h08;
    localparam logic [7:0] OFS_IEN  = 8'h0C;
    localparam logic [7:0] OFS_CMP  = 8'h10;
    localparam logic [7:0] OFS_CNT  = 8'h24;

    localparam int B_EN    = 0;
    localparam int B_WAIT  = 3;
    localparam int B_SEL   = 6;
    localparam int SEL_W   = 3;
    localparam int B_FREE  = 9;
    localparam int B_OSCEN = 10;

    localparam logic [SEL_W-1:0] SRC_BUS = 3'd1;
    localparam logic [SEL_W-1:0] SRC_PER = 3'd2;
    localparam logic [SEL_W-1:0] SRC_OSC = 3'd5;
endpackage

// File: rtl/cmt_tick_gen.sv
module cmt_tick_gen #(
    parameter int DIV_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic [cmt_pkg::SEL_W-1:0] sel,
    input  logic                    osc_en,
    input  logic [DIV_W-1:0]        div_lo,
    input  logic [DIV_W-1:0]        div_hi,
    input  logic                    tick_bus,
    input  logic                    tick_per,
    input  logic                    tick_osc,
    output logic                    tick
);
    import cmt_pkg::*;

    logic [DIV_W-1:0] ps_d, ps_q;
    logic [DIV_W-1:0] div;
    logic             src_tick;
    logic             at_tc;

    always_comb begin
        src_tick = 1'b0;
        div      = div_lo;
        case (sel)
            SRC_BUS: src_tick = tick_bus;
            SRC_PER: src_tick = tick_per;
            SRC_OSC: begin
                src_tick = tick_osc;
                if (osc_en) div = div_hi;
            end
            default: src_tick = 1'b0;
        endcase
        // >= keeps the divider bounded when the ratio shrinks mid-count
        at_tc = (ps_q >= div);
        tick  = en && src_tick && at_tc;
        ps_d  = ps_q;
        if (!en)           ps_d = '0;
        else if (src_tick) ps_d = at_tc ? '0 : ps_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ps_q <= '0;
        else        ps_q <= ps_d;
    end
endmodule

// File: rtl/cmt_count.sv
module cmt_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             free,
    input  logic [CNT_W-1:0] cmp,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt,
    output logic             flag
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } cnt_st_t;

    cnt_st_t s_d, s_q;
    logic    hit;

    always_comb begin
        s_d = s_q;
        hit = 1'b0;
        if (!en) begin
            s_d.cnt = '0;
        end else if (tick) begin
            if (!free && (s_q.cnt == cmp)) s_d.cnt = '0;
            else                           s_d.cnt = s_q.cnt + 1'b1;
            hit = (s_d.cnt == cmp);
        end
        if (clr) s_d.flag = 1'b0;
        if (hit) s_d.flag = 1'b1;   // a new match beats a clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt  = s_q.cnt;
    assign flag = s_q.flag;
endmodule

// File: rtl/cmt_timer.sv
module cmt_timer #(
    parameter int CNT_W    = 32,
    parameter int DATA_W   = 32,
    parameter int PRE_LO_W = 12,
    parameter int PRE_HI_W = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    input  logic        bus_wr,
    input  logic        bus_rd,
    output logic [31:0] bus_rdata,
    input  logic        tick_bus,
    input  logic        tick_per,
    input  logic        tick_osc,
    output logic        irq
);
    import cmt_pkg::*;

    localparam int PRE_HI_LSB = PRE_LO_W;
    localparam int DIV_W      = (PRE_LO_W > PRE_HI_W) ? PRE_LO_W : PRE_HI_W;

    typedef struct packed {
        logic                en;
        logic                wait_f;
        logic [SEL_W-1:0]    sel;
        logic                free;
        logic                osc_en;
        logic [PRE_LO_W-1:0] pre_lo;
        logic [PRE_HI_W-1:0] pre_hi;
        logic                ien;
        logic [CNT_W-1:0]    cmp;
    } regs_t;

    regs_t            r_d, r_q;
    logic             tick;
    logic [CNT_W-1:0] cnt;
    logic             flag;
    logic             stat_clr;

    always_comb begin
        r_d      = r_q;
        stat_clr = 1'b0;
        if (bus_wr) begin
            case (bus_addr)
                OFS_CTRL: begin
                    r_d.en     = bus_wdata[B_EN];
                    r_d.wait_f = bus_wdata[B_WAIT];
                    r_d.sel    = bus_wdata[B_SEL +: SEL_W];
                    r_d.free   = bus_wdata[B_FREE];
                    r_d.osc_en = bus_wdata[B_OSCEN];
                end
                OFS_PRE: begin
                    r_d.pre_lo = bus_wdata[PRE_LO_W-1:0];
                    r_d.pre_hi = bus_wdata[PRE_HI_LSB +: PRE_HI_W];
                end
                OFS_STAT: stat_clr = bus_wdata[0];
                OFS_IEN:  r_d.ien  = bus_wdata[0];
                OFS_CMP:  r_d.cmp  = bus_wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    cmt_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (r_q.en),
        .sel      (r_q.sel),
        .osc_en   (r_q.osc_en),
        .div_lo   (DIV_W'(r_q.pre_lo)),
        .div_hi   (DIV_W'(r_q.pre_hi)),
        .tick_bus (tick_bus),
        .tick_per (tick_per),
        .tick_osc (tick_osc),
        .tick     (tick)
    );

    cmt_count #(.CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (r_q.en),
        .tick  (tick),
        .free  (r_q.free),
        .cmp   (r_q.cmp),
        .clr   (stat_clr),
        .cnt   (cnt),
        .flag  (flag)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                OFS_CTRL: begin
                    bus_rdata[B_EN]              = r_q.en;
                    bus_rdata[B_WAIT]            = r_q.wait_f;
                    bus_rdata[B_SEL +: SEL_W]    = r_q.sel;
                    bus_rdata[B_FREE]            = r_q.free;
                    bus_rdata[B_OSCEN]           = r_q.osc_en;
                end
                OFS_PRE: begin
                    bus_rdata[PRE_LO_W-1:0]           = r_q.pre_lo;
                    bus_rdata[PRE_HI_LSB +: PRE_HI_W] = r_q.pre_hi;
                end
                OFS_STAT: bus_rdata[0]       = flag;
                OFS_IEN:  bus_rdata[0]       = r_q.ien;
                OFS_CMP:  bus_rdata          = DATA_W'(r_q.cmp);
                OFS_CNT:  bus_rdata          = DATA_W'(cnt);
                default:  bus_rdata          = '0;
            endcase
        end
    end

    assign irq = flag & r_q.ien;
endmodule

// File: rtl/cmt_checker.sv
module cmt_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [7:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic             en,
    input logic             free,
    input logic             tick,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cmp,
    input logic             flag
);
    p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0));

    p_hold_no_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> $stable(cnt));

    p_free_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && free) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    p_restart_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && !free && (cnt == cmp)) |=> (cnt == '0));

    p_flag_on_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flag) && $stable(cmp)) |-> (cnt == cmp));

    p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(bus_wr && (bus_addr == 8'h08) && bus_wdata[0])) |=> flag);
endmodule

bind cmt_timer cmt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .en        (r_q.en),
    .free      (r_q.free),
    .tick      (tick),
    .cnt       (cnt),
    .cmp       (r_q.cmp),
    .flag      (flag)
);

// File: tb/sim_cmt_timer.sv
`timescale 1ns/1ps
module sim_cmt_timer;
    localparam int CW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        tick_bus = 1'b0;
    logic        tick_per = 1'b0;
    logic        tick_osc = 1'b0;
    logic        irq;

    always #2.5 clk = ~clk;

    cmt_timer #(.CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .tick_bus(tick_bus), .tick_per(tick_per), .tick_osc(tick_osc), .irq(irq)
    );

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    // monitor: compares pending expectations in the low phase
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = q.pop_front();
                act = it.is_irq ? {31'd0, irq} : bus_rdata;
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic expect_irq(input logic e, input string tag);
        item_t it;
        @(negedge clk);
        it.is_irq = 1'b1; it.exp = {31'd0, e}; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic pulse(input int src, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            case (src)
                0: tick_bus = 1'b1;
                1: tick_per = 1'b1;
                default: tick_osc = 1'b1;
            endcase
        end
        @(negedge clk);
        tick_bus = 1'b0; tick_per = 1'b0; tick_osc = 1'b0;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        expect_rd(8'h00, 32'h0, "R1 ctrl");
        expect_rd(8'h04, 32'h0, "R1 pre");
        expect_rd(8'h08, 32'h0, "R1 stat");
        expect_rd(8'h0C, 32'h0, "R1 ien");
        expect_rd(8'h10, 32'h0, "R1 cmp");
        expect_rd(8'h24, 32'h0, "R1 cnt");
        expect_irq(1'b0, "R1 irq");
        // R2 read-back masks (source 7 gives no ticks)
        wr(8'h00, 32'hFFFF_FFFF);
        expect_rd(8'h00, 32'h0000_07C9, "R2 ctrl mask");
        wr(8'h00, 32'h0);
        wr(8'h04, 32'hFFFF_FFFF);
        expect_rd(8'h04, 32'h0000_FFFF, "R2 pre mask");
        wr(8'h0C, 32'hFFFF_FFFF);
        expect_rd(8'h0C, 32'h1, "R2 ien mask");
        wr(8'h0C, 32'h0);
        wr(8'h10, 32'hDEAD_BEEF);
        expect_rd(8'h10, 32'h0000_00EF, "R2 cmp width");
        // R3 count read-only
        wr(8'h24, 32'h12);
        expect_rd(8'h24, 32'h0, "R3 cnt write ignored");
        // R5 source select
        wr(8'h04, 32'h0);
        wr(8'h10, 32'hF0);
        wr(8'h00, 32'h241);
        pulse(0, 5);
        pulse(1, 3);
        pulse(2, 2);
        expect_rd(8'h24, 32'd5, "R5 bus source only");
        wr(8'h00, 32'h281);
        pulse(1, 4);
        pulse(0, 3);
        expect_rd(8'h24, 32'd9, "R5 per source only");
        wr(8'h00, 32'h341);
        pulse(2, 2);
        expect_rd(8'h24, 32'd11, "R5 osc source");
        wr(8'h00, 32'h2C1);
        pulse(0, 2);
        pulse(1, 2);
        pulse(2, 2);
        expect_rd(8'h24, 32'd11, "R5 unused code");
        // R4 disable resets and holds
        wr(8'h00, 32'h0);
        expect_rd(8'h24, 32'd0, "R4 reset by ctrl 0");
        wr(8'h00, 32'h240);
        pulse(0, 3);
        expect_rd(8'h24, 32'd0, "R4 held while disabled");
        // R6 low prescaler, divide by 3
        wr(8'h04, 32'd2);
        wr(8'h00, 32'h241);
        pulse(0, 7);
        expect_rd(8'h24, 32'd2, "R6 7 ticks div3");
        pulse(0, 1);
        expect_rd(8'h24, 32'd2, "R6 partial");
        pulse(0, 1);
        expect_rd(8'h24, 32'd3, "R6 terminal");
        // R7 oscillator divider
        wr(8'h00, 32'h0);
        wr(8'h04, 32'h3000);
        wr(8'h00, 32'h741);
        pulse(2, 8);
        expect_rd(8'h24, 32'd2, "R7 osc div4");
        wr(8'h00, 32'h341);
        pulse(2, 3);
        expect_rd(8'h24, 32'd5, "R7 path off uses low field");
        // R8 / R13 / R9 / R11 free-run
        wr(8'h00, 32'h0);
        wr(8'h04, 32'h0);
        wr(8'h10, 32'd3);
        wr(8'h08, 32'h1);
        wr(8'h00, 32'h241);
        pulse(0, 2);
        expect_rd(8'h08, 32'h0, "R8 no flag before match");
        pulse(0, 1);
        expect_rd(8'h08, 32'h1, "R8 flag on match");
        expect_irq(1'b0, "R13 masked");
        wr(8'h0C, 32'h1);
        expect_irq(1'b1, "R13 enabled");
        wr(8'h0C, 32'h0);
        expect_irq(1'b0, "R13 remasked");
        expect_rd(8'h08, 32'h1, "R13 flag kept when masked");
        pulse(0, 2);
        expect_rd(8'h24, 32'd5, "R9 runs past match");
        wr(8'h08, 32'h0);
        expect_rd(8'h08, 32'h1, "R11 write 0 no effect");
        wr(8'h08, 32'h1);
        expect_rd(8'h08, 32'h0, "R11 write 1 clears");
        pulse(0, 250);
        expect_rd(8'h24, 32'd255, "R9 top");
        pulse(0, 1);
        expect_rd(8'h24, 32'd0, "R9 wrap to 0");
        expect_rd(8'h08, 32'h0, "R9 no flag on wrap");
        pulse(0, 3);
        expect_rd(8'h08, 32'h1, "R9 match after wrap");
        // R10 restart
        wr(8'h00, 32'h0);
        wr(8'h08, 32'h1);
        wr(8'h00, 32'h041);
        pulse(0, 3);
        expect_rd(8'h08, 32'h1, "R10 match");
        pulse(0, 1);
        expect_rd(8'h24, 32'd0, "R10 reload after match");
        wr(8'h08, 32'h1);
        pulse(0, 2);
        expect_rd(8'h24, 32'd2, "R10 counting again");
        // R12 set wins over clear in the same cycle
        @(negedge clk);
        bus_rd = 1'b0;
        tick_bus = 1'b1; bus_wr = 1'b1; bus_addr = 8'h08; bus_wdata = 32'h1;
        @(negedge clk);
        tick_bus = 1'b0; bus_wr = 1'b0;
        expect_rd(8'h08, 32'h1, "R12 set wins");
        expect_rd(8'h24, 32'd3, "R12 count at match");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule